// File: doc/BRIEF.md
# Linked-Descriptor Frame Mover

This block moves Ethernet frames between system memory and a MAC without processor involvement. It has one transmit queue and one receive queue. Each queue walks a circular chain of descriptors in memory. A descriptor is three consecutive 32-bit words: the buffer address, a config word, and the address of the next descriptor. The block reaches memory through a single-outstanding master port. Frames pass to and from the MAC as 32-bit words on valid/ready streams.

Software owns the rings and the block owns only its traversal. Software does four things: it writes a queue's start pointer, sets the queue's run bit, polls the status counters, and returns descriptors. Ownership of each descriptor is decided by the empty flag in its config word. On transmit, a clear flag means the frame is ready to send. On receive, a set flag means the buffer is free to fill.

The register port uses a 3-bit word index. Bit 2 of the index selects the queue (0 transmit, 1 receive). The low two bits select the register: 0 is the pointer, 1 is control (bit 0 is run), and 2 is status.

Top module: `dma_ring_top`

## Requirements
- R1: A descriptor at address A is read as buffer address at A+0, config at A+4 and next pointer at A+8; config bit 31 is the empty flag and bits 11:0 are the length in bytes.
- R2: With transmit control bit 0 set and a fetched descriptor whose bit 31 is clear, ceil(length/4) words are read from ascending buffer addresses and sent on the transmit stream, tx_last marking the final word; a length of 0 sends no word, and tx_valid is low in the cycle after a handshake with tx_last.
- R3: After a transmit frame the config word is written back with bit 31 set and all other bits kept, and the transmit pointer takes the descriptor's next pointer.
- R4: When transmit fetches a descriptor whose bit 31 is already set, it clears transmit control bit 0 itself and its pointer stays on that descriptor.
- R5: Writing 0 to a control register lets a frame in progress finish; bit 0 reads 1 until the queue is idle, no further descriptor is fetched, and a stopped receive queue holds rx_ready low.
- R6: A pointer write is ignored while that queue's control bit 0 reads 1 and takes effect when it reads 0.
- R7: With receive control bit 0 set and a descriptor whose bit 31 is set, incoming words go to consecutive buffer words; the config word is then written with bit 31 clear and length equal to 4 times the words stored, and the pointer follows the next link.
- R8: Receive words beyond BUF_BYTES/4 are discarded without a memory write, and the stored length is then BUF_BYTES.
- R9: When the current receive descriptor has bit 31 clear, the whole incoming frame is accepted and discarded with no buffer write, receive status bit 1 is set, and the pointer does not move.
- R10: Status bits 23:16 count completed frames, saturating at 255; bit 0 reads 1 while the count is nonzero. Writing 1 to bit 0 lowers the count by one, and writing 1 to bit 1 clears the overflow flag.
- R11: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R12: A memory request keeps mem_addr, mem_we and mem_wdata stable until mem_ack; receive accesses win when both queues request at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access completes; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Transmit word valid |
| tx_data | output | 32 | Transmit word |
| tx_last | output | 1 | Final word of a transmit frame |
| tx_ready | input | 1 | MAC accepts transmit word |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | 32 | Receive word |
| rx_last | input | 1 | Final word of a receive frame |
| rx_ready | output | 1 | Block accepts receive word |

## Verification
Some properties are checked on every cycle. These are the holding of the transmit stream under back-pressure, the stability of a pending memory request, the one-cycle gap after a transmit frame, the bound on the receive word index and the single-step movement of the status counters. The scenarios are what show descriptor ownership: which descriptors are sent, skipped or filled, what is written back, and where each pointer ends. They also show the stop handshake, ring-full dropping, truncation at the buffer limit, and pointer writes ignored while a queue is busy.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

    localparam int WORD_W     = 32;
    localparam int EMPTY_BIT  = 31;
    localparam int OFS_BUF    = 0;
    localparam int OFS_CFG    = 4;
    localparam int OFS_NXT    = 8;

    typedef enum logic [2:0] {
        TX_IDLE, TX_RD_CFG, TX_RD_BUF, TX_RD_NXT, TX_RD_DAT, TX_SEND, TX_WB
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_RD_CFG, RX_RD_BUF, RX_RD_NXT, RX_RECV, RX_WR_DAT, RX_WB, RX_DROP
    } rx_st_e;

endpackage

// File: rtl/dma_ring_stat.sv
module dma_ring_stat #(
    parameter int CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        done_i,
    input  logic        ovf_i,
    input  logic        we_i,
    input  logic [1:0]  wbits_i,
    output logic [31:0] stat_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } stat_t;

    stat_t q, d;

    always_comb begin
        logic inc, dec;
        d   = q;
        inc = done_i && (q.cnt != CNT_MAX);
        dec = we_i && wbits_i[0] && (q.cnt != '0);
        if (inc && !dec)      d.cnt = q.cnt + CNT_W'(1);
        else if (dec && !inc) d.cnt = q.cnt - CNT_W'(1);
        if (ovf_i)                     d.ovf = 1'b1;
        else if (we_i && wbits_i[1])   d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stat_o = (32'(q.cnt) << 16) | {30'b0, q.ovf, (q.cnt != '0)};

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != $past(q.cnt)) |-> (q.cnt == $past(q.cnt) + CNT_W'(1) || q.cnt == $past(q.cnt) - CNT_W'(1))); // R10

endmodule

// File: rtl/dma_ring_arb.sv
module dma_ring_arb (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_req_i,
    input  logic        tx_we_i,
    input  logic [31:0] tx_addr_i,
    input  logic [31:0] tx_wdata_i,
    output logic        tx_ack_o,
    input  logic        rx_req_i,
    input  logic        rx_we_i,
    input  logic [31:0] rx_addr_i,
    input  logic [31:0] rx_wdata_i,
    output logic        rx_ack_o,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    input  logic        mem_ack_i
);
    typedef struct packed {
        logic lock;
        logic sel_rx;
    } arb_t;

    arb_t q, d;
    logic sel_rx;

    always_comb begin
        sel_rx      = q.lock ? q.sel_rx : rx_req_i;
        mem_req_o   = sel_rx ? rx_req_i   : tx_req_i;
        mem_we_o    = sel_rx ? rx_we_i    : tx_we_i;
        mem_addr_o  = sel_rx ? rx_addr_i  : tx_addr_i;
        mem_wdata_o = sel_rx ? rx_wdata_i : tx_wdata_i;
        rx_ack_o    = sel_rx && mem_ack_i;
        tx_ack_o    = !sel_rx && mem_ack_i;
        d.lock      = mem_req_o && !mem_ack_i;
        d.sel_rx    = sel_rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o))); // R12

endmodule

// File: rtl/dma_ring_tx.sv
module dma_ring_tx
    import dma_ring_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ptr_we_i,
    input  logic [31:0] ptr_wdata_i,
    input  logic        ctrl_we_i,
    input  logic        ctrl_run_i,
    output logic [31:0] ptr_o,
    output logic        ctrl_rd_o,
    output logic        done_o,
    output logic        req_o,
    output logic        we_o,
    output logic [31:0] addr_o,
    output logic [31:0] wdata_o,
    input  logic        ack_i,
    input  logic [31:0] rdata_i,
    output logic        tx_valid_o,
    output logic [31:0] tx_data_o,
    output logic        tx_last_o,
    input  logic        tx_ready_i
);
    typedef struct packed {
        tx_st_e          st;
        logic            run;
        logic [31:0]     ptr;
        logic [31:0]     bufa;
        logic [31:0]     nxt;
        logic [31:0]     cfg;
        logic [LEN_W-1:0] idx;
        logic [31:0]     data;
    } tx_t;

    tx_t q, d;
    logic [LEN_W-1:0] nwords;
    logic             last_word;

    assign nwords    = LEN_W'(({1'b0, q.cfg[LEN_W-1:0]} + (LEN_W+1)'(3)) >> 2);
    assign last_word = (q.idx + LEN_W'(1)) == nwords;
    assign ctrl_rd_o = q.run || (q.st != TX_IDLE);

    always_comb begin
        d       = q;
        done_o  = 1'b0;
        req_o   = 1'b0;
        we_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        if (ctrl_we_i) d.run = ctrl_run_i;
        if (ptr_we_i && !ctrl_rd_o) d.ptr = ptr_wdata_i;
        case (q.st)
            TX_IDLE: if (d.run) d.st = TX_RD_CFG;
            TX_RD_CFG: begin
                req_o  = 1'b1;
                addr_o = q.ptr + 32'(OFS_CFG);
                if (ack_i) begin
                    if (rdata_i[EMPTY_BIT]) begin
                        d.run = 1'b0;
                        d.st  = TX_IDLE;
                    end else begin
                        d.cfg = rdata_i;
                        d.st  = TX_RD_BUF;
                    end
                end
            end
            TX_RD_BUF: begin
                req_o  = 1'b1;
                addr_o = q.ptr + 32'(OFS_BUF);
                if (ack_i) begin
                    d.bufa = rdata_i;
                    d.st   = TX_RD_NXT;
                end
            end
            TX_RD_NXT: begin
                req_o  = 1'b1;
                addr_o = q.ptr + 32'(OFS_NXT);
                if (ack_i) begin
                    d.nxt = rdata_i;
                    d.idx = '0;
                    d.st  = (nwords == '0) ? TX_WB : TX_RD_DAT;
                end
            end
            TX_RD_DAT: begin
                req_o  = 1'b1;
                addr_o = q.bufa + 32'({q.idx, 2'b00});
                if (ack_i) begin
                    d.data = rdata_i;
                    d.st   = TX_SEND;
                end
            end
            TX_SEND: begin
                if (tx_ready_i) begin
                    d.idx = q.idx + LEN_W'(1);
                    d.st  = last_word ? TX_WB : TX_RD_DAT;
                end
            end
            TX_WB: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                addr_o  = q.ptr + 32'(OFS_CFG);
                wdata_o = q.cfg | (32'd1 << EMPTY_BIT);
                if (ack_i) begin
                    d.ptr  = q.nxt;
                    done_o = 1'b1;
                    d.st   = TX_IDLE;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ptr_o      = q.ptr;
    assign tx_valid_o = (q.st == TX_SEND);
    assign tx_data_o  = q.data;
    assign tx_last_o  = (q.st == TX_SEND) && last_word;

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o))); // R11

    AST_TX_END_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_ready_i && tx_last_o) |=> !tx_valid_o); // R2

endmodule

// File: rtl/dma_ring_rx.sv
module dma_ring_rx
    import dma_ring_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int LEN_W     = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ptr_we_i,
    input  logic [31:0] ptr_wdata_i,
    input  logic        ctrl_we_i,
    input  logic        ctrl_run_i,
    output logic [31:0] ptr_o,
    output logic        ctrl_rd_o,
    output logic        done_o,
    output logic        ovf_o,
    output logic        req_o,
    output logic        we_o,
    output logic [31:0] addr_o,
    output logic [31:0] wdata_o,
    input  logic        ack_i,
    input  logic [31:0] rdata_i,
    input  logic        rx_valid_i,
    input  logic [31:0] rx_data_i,
    input  logic        rx_last_i,
    output logic        rx_ready_o
);
    localparam int MAX_WORDS = BUF_BYTES / 4;
    localparam int IDX_W     = $clog2(MAX_WORDS) + 1;

    typedef struct packed {
        rx_st_e          st;
        logic            run;
        logic [31:0]     ptr;
        logic [31:0]     bufa;
        logic [31:0]     nxt;
        logic [IDX_W-1:0] idx;
        logic [31:0]     data;
        logic            last;
    } rx_t;

    rx_t q, d;

    assign ctrl_rd_o = q.run || (q.st != RX_IDLE);

    always_comb begin
        d          = q;
        done_o     = 1'b0;
        ovf_o      = 1'b0;
        req_o      = 1'b0;
        we_o       = 1'b0;
        addr_o     = '0;
        wdata_o    = '0;
        rx_ready_o = 1'b0;
        if (ctrl_we_i) d.run = ctrl_run_i;
        if (ptr_we_i && !ctrl_rd_o) d.ptr = ptr_wdata_i;
        case (q.st)
            RX_IDLE: if (d.run && rx_valid_i) d.st = RX_RD_CFG;
            RX_RD_CFG: begin
                req_o  = 1'b1;
                addr_o = q.ptr + 32'(OFS_CFG);
                if (ack_i) begin
                    if (rdata_i[EMPTY_BIT]) begin
                        d.st = RX_RD_BUF;
                    end else begin
                        ovf_o = 1'b1;
                        d.st  = RX_DROP;
                    end
                end
            end
            RX_RD_BUF: begin
                req_o  = 1'b1;
                addr_o = q.ptr + 32'(OFS_BUF);
                if (ack_i) begin
                    d.bufa = rdata_i;
                    d.st   = RX_RD_NXT;
                end
            end
            RX_RD_NXT: begin
                req_o  = 1'b1;
                addr_o = q.ptr + 32'(OFS_NXT);
                if (ack_i) begin
                    d.nxt = rdata_i;
                    d.idx = '0;
                    d.st  = RX_RECV;
                end
            end
            RX_RECV: begin
                rx_ready_o = 1'b1;
                if (rx_valid_i) begin
                    d.data = rx_data_i;
                    d.last = rx_last_i;
                    if (q.idx < IDX_W'(MAX_WORDS)) d.st = RX_WR_DAT;
                    else if (rx_last_i)            d.st = RX_WB;
                end
            end
            RX_WR_DAT: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                addr_o  = q.bufa + 32'({q.idx, 2'b00});
                wdata_o = q.data;
                if (ack_i) begin
                    d.idx = q.idx + IDX_W'(1);
                    d.st  = q.last ? RX_WB : RX_RECV;
                end
            end
            RX_WB: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                addr_o  = q.ptr + 32'(OFS_CFG);
                wdata_o = 32'(LEN_W'({q.idx, 2'b00}));
                if (ack_i) begin
                    d.ptr  = q.nxt;
                    done_o = 1'b1;
                    d.st   = RX_IDLE;
                end
            end
            RX_DROP: begin
                rx_ready_o = 1'b1;
                if (rx_valid_i && rx_last_i) d.st = RX_IDLE;
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ptr_o = q.ptr;

    AST_RX_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= IDX_W'(MAX_WORDS)); // R8

    AST_RX_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready_o |-> !req_o); // R12

endmodule

// File: rtl/dma_ring_top.sv
module dma_ring_top #(
    parameter int BUF_BYTES = 2048,
    parameter int LEN_W     = 12,
    parameter int CNT_W     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [31:0] tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [31:0] rx_data,
    input  logic        rx_last,
    output logic        rx_ready
);
    localparam logic [1:0] SEL_PTR  = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    logic        q_rx;
    logic [1:0]  sel;
    assign q_rx = reg_addr[2];
    assign sel  = reg_addr[1:0];

    logic        tx_ptr_we, tx_ctrl_we, tx_stat_we;
    logic        rx_ptr_we, rx_ctrl_we, rx_stat_we;
    assign tx_ptr_we  = reg_we && !q_rx && (sel == SEL_PTR);
    assign tx_ctrl_we = reg_we && !q_rx && (sel == SEL_CTRL);
    assign tx_stat_we = reg_we && !q_rx && (sel == SEL_STAT);
    assign rx_ptr_we  = reg_we &&  q_rx && (sel == SEL_PTR);
    assign rx_ctrl_we = reg_we &&  q_rx && (sel == SEL_CTRL);
    assign rx_stat_we = reg_we &&  q_rx && (sel == SEL_STAT);

    logic [31:0] tx_ptr, rx_ptr, tx_stat, rx_stat;
    logic        tx_ctrl, rx_ctrl, tx_done, rx_done, rx_ovf;
    logic        tx_req, tx_mwe, tx_ack, rx_req, rx_mwe, rx_ack;
    logic [31:0] tx_maddr, tx_mwdata, rx_maddr, rx_mwdata;

    dma_ring_tx #(.LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .ptr_we_i(tx_ptr_we), .ptr_wdata_i(reg_wdata),
        .ctrl_we_i(tx_ctrl_we), .ctrl_run_i(reg_wdata[0]),
        .ptr_o(tx_ptr), .ctrl_rd_o(tx_ctrl), .done_o(tx_done),
        .req_o(tx_req), .we_o(tx_mwe), .addr_o(tx_maddr), .wdata_o(tx_mwdata),
        .ack_i(tx_ack), .rdata_i(mem_rdata),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
        .tx_ready_i(tx_ready)
    );

    dma_ring_rx #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .ptr_we_i(rx_ptr_we), .ptr_wdata_i(reg_wdata),
        .ctrl_we_i(rx_ctrl_we), .ctrl_run_i(reg_wdata[0]),
        .ptr_o(rx_ptr), .ctrl_rd_o(rx_ctrl), .done_o(rx_done), .ovf_o(rx_ovf),
        .req_o(rx_req), .we_o(rx_mwe), .addr_o(rx_maddr), .wdata_o(rx_mwdata),
        .ack_i(rx_ack), .rdata_i(mem_rdata),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
        .rx_ready_o(rx_ready)
    );

    dma_ring_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .tx_req_i(tx_req), .tx_we_i(tx_mwe), .tx_addr_i(tx_maddr), .tx_wdata_i(tx_mwdata),
        .tx_ack_o(tx_ack),
        .rx_req_i(rx_req), .rx_we_i(rx_mwe), .rx_addr_i(rx_maddr), .rx_wdata_i(rx_mwdata),
        .rx_ack_o(rx_ack),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack)
    );

    dma_ring_stat #(.CNT_W(CNT_W)) u_tx_stat (
        .clk(clk), .rst_n(rst_n), .done_i(tx_done), .ovf_i(1'b0),
        .we_i(tx_stat_we), .wbits_i(reg_wdata[1:0]), .stat_o(tx_stat)
    );

    dma_ring_stat #(.CNT_W(CNT_W)) u_rx_stat (
        .clk(clk), .rst_n(rst_n), .done_i(rx_done), .ovf_i(rx_ovf),
        .we_i(rx_stat_we), .wbits_i(reg_wdata[1:0]), .stat_o(rx_stat)
    );

    always_comb begin
        case (reg_addr)
            3'd0:    reg_rdata = tx_ptr;
            3'd1:    reg_rdata = {31'b0, tx_ctrl};
            3'd2:    reg_rdata = tx_stat;
            3'd4:    reg_rdata = rx_ptr;
            3'd5:    reg_rdata = {31'b0, rx_ctrl};
            3'd6:    reg_rdata = rx_stat;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/dma_ring_top_tb.sv
module dma_ring_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic [31:0] tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_ready;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] mem [logic [31:0]];
    logic [32:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_ring_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready)
    );

    function automatic logic [31:0] mrd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: acknowledges each request one cycle after it appears
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) mem_ack = 1'b0;
            else if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (mem_we) mem[mem_addr] = mem_wdata;
                else        mem_rdata = mrd(mem_addr);
                mem_ack = 1'b1;
            end
        end
    end

    // monitor: pops expected transmit words at each handshake
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    checks++; bad++;
                    $display("FAIL R2 unexpected word actual=%h expected=none", tx_data);
                end else begin
                    logic [32:0] e;
                    e = exp_q.pop_front();
                    check("R2 tx word", {tx_last, tx_data}, e[31:0] | 32'h0);
                    check("R2 tx_last", {31'b0, tx_last}, {31'b0, e[32]});
                end
            end
        end
    end

    task automatic push_tx(logic [31:0] buf_a, int len);
        int nw;
        nw = (len + 3) / 4;
        for (int i = 0; i < nw; i++)
            exp_q.push_back({(i == nw - 1), mrd(buf_a + 32'(4 * i))});
    endtask

    task automatic reg_wr(logic [2:0] a, logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_reg(logic [2:0] a, logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 20000; i++) begin
            reg_rd(a, r);
            if (r == v) return;
        end
    endtask

    task automatic rx_send(int n, logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = base + 32'(i); rx_last = (i == n - 1);
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        reg_rd(3'd0, r); check("R6 reset tx ptr", r, 32'h0);
        reg_rd(3'd1, r); check("R5 reset tx ctrl", r, 32'h0);
        reg_rd(3'd6, r); check("R10 reset rx stat", r, 32'h0);
        check("R12 reset mem_req", {31'b0, mem_req}, 32'h0);
        check("R5 reset rx_ready", {31'b0, rx_ready}, 32'h0);

        // transmit ring: desc0 len 8, desc1 len 5, desc2 empty (R1 layout)
        mem[32'h1000] = 32'h2000; mem[32'h1004] = 32'h8;          mem[32'h1008] = 32'h1010;
        mem[32'h1010] = 32'h2100; mem[32'h1014] = 32'h5;          mem[32'h1018] = 32'h1020;
        mem[32'h1020] = 32'h2200; mem[32'h1024] = 32'h8000_0000;  mem[32'h1028] = 32'h1000;
        mem[32'h2000] = 32'hA000_0000; mem[32'h2004] = 32'hA000_0001;
        mem[32'h2100] = 32'hB000_0000; mem[32'h2104] = 32'hB000_0001;
        push_tx(32'h2000, 8);
        push_tx(32'h2100, 5);
        tx_ready = 1'b1;
        reg_wr(3'd0, 32'h1000);
        reg_wr(3'd1, 32'h1);
        wait_reg(3'd1, 32'h0);
        check("R4 tx self-stop", {31'b0, dut_ctrl_dummy()}, 32'h0);
        reg_rd(3'd0, r); check("R4 tx ptr stays on empty desc", r, 32'h1020);
        check("R3 desc0 writeback", mrd(32'h1004), 32'h8000_0008);
        check("R3 desc1 writeback", mrd(32'h1014), 32'h8000_0005);
        reg_rd(3'd2, r); check("R10 tx count 2", r, 32'h0002_0001);
        check("R2 all words sent", 32'(exp_q.size()), 32'h0);

        // zero-length frame, ring wraps to emptied desc0
        mem[32'h1024] = 32'h0;
        reg_wr(3'd1, 32'h1);
        wait_reg(3'd1, 32'h0);
        check("R2 zero length writeback", mrd(32'h1024), 32'h8000_0000);
        reg_rd(3'd0, r); check("R3 tx ptr wrapped", r, 32'h1000);
        reg_rd(3'd2, r); check("R10 tx count 3", r, 32'h0003_0001);

        // status decrement
        reg_wr(3'd2, 32'h1);
        reg_rd(3'd2, r); check("R10 decrement", r, 32'h0002_0001);

        // stop while a frame is stalled
        mem[32'h1004] = 32'h4; mem[32'h1014] = 32'h4; mem[32'h2000] = 32'hC000_0000;
        push_tx(32'h2000, 4);
        @(posedge clk); #1 tx_ready = 1'b0;
        reg_wr(3'd1, 32'h1);
        for (int i = 0; i < 100 && !tx_valid; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R11 valid held while stalled", {31'b0, tx_valid}, 32'h1);
        reg_wr(3'd0, 32'h3000);
        reg_wr(3'd1, 32'h0);
        reg_rd(3'd1, r); check("R5 ctrl reads 1 while busy", r, 32'h1);
        reg_rd(3'd0, r); check("R6 ptr write ignored", r, 32'h1000);
        @(posedge clk); #1 tx_ready = 1'b1;
        wait_reg(3'd1, 32'h0);
        reg_rd(3'd0, r); check("R5 ptr after stop", r, 32'h1010);
        check("R5 next desc untouched", mrd(32'h1014), 32'h4);
        reg_rd(3'd2, r); check("R5 one frame done", r, 32'h0003_0001);

        // receive ring
        mem[32'h4000] = 32'h5000; mem[32'h4004] = 32'h8000_0000; mem[32'h4008] = 32'h4010;
        mem[32'h4010] = 32'h5800; mem[32'h4014] = 32'h8000_0000; mem[32'h4018] = 32'h4000;
        reg_wr(3'd4, 32'h4000);
        reg_rd(3'd4, r); check("R6 ptr write when stopped", r, 32'h4000);
        reg_wr(3'd5, 32'h1);
        rx_send(3, 32'hD000_0000);
        wait_reg(3'd6, 32'h0001_0001);
        check("R7 rx word0", mrd(32'h5000), 32'hD000_0000);
        check("R7 rx word2", mrd(32'h5008), 32'hD000_0002);
        check("R7 rx cfg", mrd(32'h4004), 32'h0000_000C);
        rx_send(2, 32'hE000_0000);
        wait_reg(3'd6, 32'h0002_0001);
        check("R7 rx desc1 cfg", mrd(32'h4014), 32'h0000_0008);
        check("R7 rx desc1 word1", mrd(32'h5804), 32'hE000_0001);
        reg_rd(3'd4, r); check("R7 rx ptr wrapped", r, 32'h4000);

        // ring full
        rx_send(2, 32'hF000_0000);
        repeat (4) @(negedge clk);
        reg_rd(3'd6, r); check("R9 overflow flag", r, 32'h0002_0003);
        check("R9 buffer untouched", mrd(32'h5000), 32'hD000_0000);
        reg_rd(3'd4, r); check("R9 ptr unchanged", r, 32'h4000);
        reg_wr(3'd6, 32'h2);
        reg_rd(3'd6, r); check("R10 overflow clear", r, 32'h0002_0001);

        // truncation
        mem[32'h4004] = 32'h8000_0000;
        rx_send(515, 32'h9000_0000);
        wait_reg(3'd6, 32'h0003_0001);
        check("R8 truncated length", mrd(32'h4004), 32'h0000_0800);
        check("R8 last stored word", mrd(32'h57FC), 32'h9000_01FF);
        check("R8 neighbour buffer kept", mrd(32'h5800), 32'hE000_0000);
        reg_rd(3'd4, r); check("R7 rx ptr advanced", r, 32'h4010);

        // stopped receive ignores input
        reg_wr(3'd5, 32'h0);
        reg_rd(3'd5, r); check("R5 rx stopped", r, 32'h0);
        @(negedge clk); rx_valid = 1'b1; rx_data = 32'h1234_5678; rx_last = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (rx_ready) seen++;
            end
            check("R5 rx_ready low when stopped", 32'(seen), 32'h0);
        end
        rx_valid = 1'b0; rx_last = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    function automatic logic dut_ctrl_dummy();
        return reg_rdata[0];
    endfunction

endmodule